// File: doc/BRIEF.md
# Sub-Audio NRZ Byte Receiver with Clock Recovery

This block turns a one-bit sliced sub-audio signal, as produced by an external analog comparator, into bytes for a host processor. The sliced level is brought into the clock domain and then smoothed by a digital majority filter. The filter runs at sixteen samples per bit, and the bit rate is chosen by the host from four divider settings. The filtered signal drives two things: a bit-phase counter that re-aligns on every transition it sees, and a data sampler that takes the level at mid-bit.

Sampled bits are shifted in most significant bit first. Eight samples form a byte, which is loaded into a holding register. The host is told through two flags: one says a byte is waiting, and the other says a byte was replaced before the host read the one before it. A single read strobe acknowledges the byte and clears both flags. There is no start bit or framing. Bit alignment is taken from the first filtered transition after reset or after the receiver wakes. Finding the coded squelch word in the stream is left to the host. A sleep input forces the sliced input to logic 0 and drops the alignment, so no bytes form while the receiver is powered down.

Top module: `nrz_byte_rx`

## Requirements
- R1: The synchronized input is sampled once per oversample tick. The filtered level is the majority (at least 3 of 5) of the current sample and the four samples before it. A disturbance lasting a single tick never changes a received byte.
- R2: `baud_sel` values 0, 1, 2 and 3 set the tick length to DIV0, DIV1, DIV2 and DIV3 clocks. The defaults are 4, 6, 9 and 13 clocks. One bit lasts OSR (default 16) ticks.
- R3: Every change of the filtered level resets the bit phase. Data is sampled OSR/2 ticks after that change, and then every OSR ticks until the next change. This allows a sender whose bit period is off by a few clocks to be received correctly, as long as the data has transitions.
- R4: Bits enter most significant bit first. Counting starts at the first filtered transition after reset or wake; because the line idles low, the first bit is a 1. After every eighth sample the completed byte is loaded into `rx_byte`.
- R5: `byte_flag` goes to 1 in the cycle after a byte is loaded. `rx_byte` changes only when a new byte is loaded.
- R6: Suppose a byte completes while `byte_flag` is 1 and `rd_strobe` is 0. Then `ovr_flag` goes to 1 and `rx_byte` takes the new byte. `ovr_flag` is never 1 while `byte_flag` is 0.
- R7: A cycle with `rd_strobe` high clears `byte_flag` and `ovr_flag`. If a byte completes in that same cycle, `byte_flag` is set again and `ovr_flag` stays 0.
- R8: While `sleep` is 1, the sliced input is treated as 0 and the alignment is dropped. No byte is assembled until a new transition arrives after `sleep` returns to 0.
- R9: After reset, `rx_byte` is 0, `byte_flag` is 0 and `ovr_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| sleep | input | 1 | Power-down: input forced low, alignment dropped |
| slice_in | input | 1 | Sliced sub-audio level from the comparator |
| baud_sel | input | 2 | Bit rate select (tick length DIV0..DIV3 clocks) |
| rd_strobe | input | 1 | Host read acknowledge, one cycle |
| rx_byte | output | 8 | Most recently completed byte |
| byte_flag | output | 1 | Byte waiting for the host |
| ovr_flag | output | 1 | A byte was replaced before being read |

## Verification
Byte pairs are sent at all four bit rates. The patterns include alternating bits, long runs of equal bits and mirrored nibbles. These show whether the divider selection, the shift order and the mid-bit sample point are right. Some pairs are sent with the sender's bit period a few clocks long or short. A receiver that does not re-align on transitions slips a bit in these cases, while one that does re-align stays correct. Further tests use single-tick glitches inside every bit, two unread bytes in a row, and a byte sent while asleep. These show the filter's rejection, the overrun and read-clear handling, and that the power-down gating holds.

// File: rtl/nrz_byte_rx.sv
module nrz_byte_rx #(
  parameter int OSR    = 16,
  parameter int DIV0   = 4,
  parameter int DIV1   = 6,
  parameter int DIV2   = 9,
  parameter int DIV3   = 13,
  parameter int DIV_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              slice_in,
  input  logic [1:0]        baud_sel,
  input  logic              rd_strobe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_flag,
  output logic              ovr_flag
);
  localparam int PH_W = $clog2(OSR);
  localparam int BC_W = $clog2(BYTE_W);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OSR/2 - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BYTE_W - 1);

  logic [1:0]        sync;
  logic [DIV_W-1:0]  div_lim, dcnt;
  logic [3:0]        win;
  logic              filt, maj, tick, edge_t, sample, byte_done, locked;
  logic [PH_W-1:0]   phase;
  logic [BC_W-1:0]   bitcnt;
  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[0], slice_in & ~sleep};

  always_comb
    case (baud_sel)
      2'd0:    div_lim = DIV_W'(DIV0);
      2'd1:    div_lim = DIV_W'(DIV1);
      2'd2:    div_lim = DIV_W'(DIV2);
      default: div_lim = DIV_W'(DIV3);
    endcase

  assign tick = (dcnt >= div_lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    dcnt <= '0;
    else if (tick) dcnt <= '0;
    else           dcnt <= dcnt + 1'b1;

  always_comb maj = ($countones({win, sync[1]}) >= 3);

  assign edge_t    = tick && (maj != filt);
  assign sample    = tick && locked && !edge_t && (phase == PH_MID);
  assign byte_done = sample && (bitcnt == BC_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      win    <= '0;
      filt   <= 1'b0;
      phase  <= '0;
      locked <= 1'b0;
    end else begin
      if (tick) begin
        win   <= {win[2:0], sync[1]};
        filt  <= maj;
        phase <= (edge_t || phase == PH_LAST) ? '0 : phase + 1'b1;
      end
      if (sleep)       locked <= 1'b0;
      else if (edge_t) locked <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
    end else if (!locked || sleep) begin
      bitcnt <= '0;
    end else if (sample) begin
      shreg  <= {shreg[BYTE_W-2:0], filt};
      bitcnt <= (bitcnt == BC_LAST) ? '0 : bitcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_byte   <= '0;
      byte_flag <= 1'b0;
      ovr_flag  <= 1'b0;
    end else if (byte_done) begin
      rx_byte   <= {shreg[BYTE_W-2:0], filt};
      byte_flag <= 1'b1;
      ovr_flag  <= rd_strobe ? 1'b0 : (ovr_flag | byte_flag);
    end else if (rd_strobe) begin
      byte_flag <= 1'b0;
      ovr_flag  <= 1'b0;
    end

  assert_ovr_has_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |-> byte_flag);
  assert_ovr_only_on_unread_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(byte_flag) && !$past(rd_strobe));
  assert_byte_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(rx_byte));
  assert_flag_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> byte_flag);
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !byte_done) |=> (!byte_flag && !ovr_flag));
  assert_read_same_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && byte_done) |=> (byte_flag && !ovr_flag));
  assert_sleep_no_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sleep) |-> !byte_done);
  assert_sample_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_t |=> (phase == '0));
endmodule

// File: tb/sim_nrz_byte_rx.sv
module sim_nrz_byte_rx;
  logic clk = 1'b0, rst_n = 1'b0, sleep = 1'b0, slice_in = 1'b0, rd_strobe = 1'b0;
  logic [1:0] baud_sel = 2'd0;
  logic [7:0] rx_byte;
  logic byte_flag, ovr_flag;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nrz_byte_rx u0 (.clk(clk), .rst_n(rst_n), .sleep(sleep), .slice_in(slice_in),
    .baud_sel(baud_sel), .rd_strobe(rd_strobe), .rx_byte(rx_byte),
    .byte_flag(byte_flag), .ovr_flag(ovr_flag));

  // {sel[1:0], skew[5:0] two's complement clocks per bit, first byte, second byte}
  localparam logic [23:0] VEC [8] = '{
    24'h00C33C, 24'h40A55A, 24'h80F00F, 24'hC0817E,
    24'h02AA55, 24'hFDB44B, 24'h439669, 24'h80FF00 };

  function automatic int div_of(input logic [1:0] s);
    case (s)
      2'd0: return 4;
      2'd1: return 6;
      2'd2: return 9;
      default: return 13;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pair(input logic [1:0] s, input int skew, input logic [7:0] b0,
                           input logic [7:0] b1, input bit glitch);
    int d = div_of(s);
    int per = 16 * d + skew;
    logic [15:0] bits = {b0, b1};
    for (int i = 15; i >= 0; i--) begin
      slice_in = bits[i];
      if (glitch) begin
        clocks(per / 4);
        slice_in = ~bits[i];
        clocks(d);
        slice_in = bits[i];
        clocks(per - per / 4 - d);
      end else clocks(per);
    end
  endtask

  task automatic wait_flag(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (byte_flag) begin ok = 1'b1; break; end
    end
  endtask

  task automatic pulse_read;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic get_byte(output logic [7:0] v, output bit ok);
    wait_flag(ok);
    v = rx_byte;
    if (ok) pulse_read();
  endtask

  task automatic rx_pair(input string tag, input logic [1:0] s, input int skew,
                         input logic [7:0] b0, input logic [7:0] b1, input bit glitch);
    logic [7:0] g0, g1;
    bit ok0, ok1;
    sleep = 1'b1; slice_in = 1'b0;
    clocks(600);
    baud_sel = s;
    sleep = 1'b0;
    clocks(20);
    fork
      send_pair(s, skew, b0, b1, glitch);
      begin
        get_byte(g0, ok0);
        get_byte(g1, ok1);
      end
    join
    sleep = 1'b1;
    chk({tag, " first byte"}, {ok0, g0}, {1'b1, b0});
    chk({tag, " second byte"}, {ok1, g1}, {1'b1, b1});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    bit ok;
    clocks(5);
    chk("R9 reset outputs", {rx_byte, byte_flag, ovr_flag}, 10'h000);
    rst_n = 1'b1;
    clocks(5);

    // R2 R3 R4 R5: table of bit rates, skews and patterns
    for (int k = 0; k < 8; k++) begin
      logic [23:0] e = VEC[k];
      int sk = int'($signed(e[21:16]));
      rx_pair($sformatf("R2 R3 R4 vec%0d", k), e[23:22], sk, e[15:8], e[7:0], 1'b0);
    end

    // R1: single-tick glitch in every bit
    rx_pair("R1 glitch", 2'd1, 0, 8'hE7, 8'h18, 1'b1);
    rx_pair("R1 glitch slow", 2'd3, 0, 8'hB2, 8'h4D, 1'b1);

    // R5 R6 R7: overrun
    sleep = 1'b1; slice_in = 1'b0; clocks(600);
    baud_sel = 2'd0; sleep = 1'b0; clocks(20);
    fork
      send_pair(2'd0, 0, 8'hC3, 8'h3C, 1'b0);
      begin
        wait_flag(ok);
        chk("R5 first byte loaded", {ok, rx_byte, ovr_flag}, {1'b1, 8'hC3, 1'b0});
        clocks(100);
        chk("R5 byte held", rx_byte, 8'hC3);
      end
    join
    sleep = 1'b1;
    chk("R6 overrun flags", {byte_flag, ovr_flag}, 2'b11);
    chk("R6 newest byte kept", rx_byte, 8'h3C);
    clocks(3);
    pulse_read();
    chk("R7 read clears flags", {byte_flag, ovr_flag}, 2'b00);
    chk("R7 data after read", rx_byte, 8'h3C);

    // R8: traffic while asleep
    clocks(600);
    send_pair(2'd0, 0, 8'hA5, 8'h5A, 1'b0);
    clocks(200);
    chk("R8 no byte while asleep", {byte_flag, ovr_flag, rx_byte}, {2'b00, 8'h3C});
    slice_in = 1'b0;
    rx_pair("R8 after wake", 2'd2, 0, 8'hD1, 8'h2E, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule